// File: doc/BRIEF.md
# Slot-Voting Asynchronous Serial Receiver

This block takes an idle-high asynchronous serial line and recovers frames of up to 16 bits from it. Each bit period is cut into 16 equal sample slots. The length of one slot comes from a programmable rate value. Inside every bit, the receiver takes one sample per slot, but only for the slots that fall inside a programmable window. A bit is accepted as high or low only when every sample in that window agrees. When the samples disagree, a sticky sampling-error flag is raised and the bit is stored as 0.

Received bits enter the top of a hold register and move down one place per bit, so the first bit of the frame ends up lowest. The hold register is loaded as a whole when the last programmed bit completes. At that point the ready flag rises. If ready was still set, the overflow flag rises too. A single clear strobe drops all three flags. An optional 3-sample majority filter can clean the line before it is used, and the conditioned line level is always visible on an output.

The frame output works like a stream without back-pressure. `rdy` plays the role of valid and `clr_flags` plays the role of the consumer's acknowledge. The line cannot be stalled. A frame that completes before the acknowledge replaces `hold_q` and is reported through `ovf`.

Top module: `slot_vote_rx`

## Requirements
- R1: One slot lasts floor(rate_inc/16) clock cycles, with a minimum of one cycle (a rate value below 16 gives one-cycle slots). One bit lasts 16 slots.
- R2: A frame starts only on a high-to-low transition of the conditioned line while the receiver is enabled and idle. Slot 0 begins on the next clock. A line that stays high starts nothing.
- R3: One sample is taken on the first clock of each slot whose index lies in the inclusive range win_lo..win_hi. A bit is 1 only if all of these samples are high, and 0 otherwise. If the samples are neither all high nor all low, smp_err is set and stays set.
- R4: bit_count gives the number of bits per frame, and the value 0 means 16. After the last bit the receiver returns to idle and waits for the next falling edge.
- R5: When a frame of n bits completes, hold_q holds the first received bit at position 16-n and the last at position 15, with zeros below. hold_q changes at no other time.
- R6: rdy becomes 1 on the clock after the last bit of a frame is decided.
- R7: If a frame completes while rdy is already 1, ovf becomes 1 and hold_q takes the new frame.
- R8: A one-cycle pulse on clr_flags clears rdy, ovf and smp_err on the next clock. A flag event in the same cycle still sets its flag.
- R9: line_lvl shows the conditioned line. Without the filter, it follows rx_line three clocks later.
- R10: With filt_en set, the conditioned line is the majority of the last three synchronised samples. A pulse of one clock never reaches line_lvl.
- R11: While rx_en is 0, no frame starts and any frame in progress is dropped. Line activity leaves hold_q, rdy, ovf and smp_err unchanged.
- R12: After reset, hold_q is 0, all three flags are 0 and line_lvl is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_en | input | 1 | Receiver enable |
| rx_line | input | 1 | Serial line, idle high |
| rate_inc | input | 16 | Rate value; the slot length is rate_inc/16 clocks |
| bit_count | input | 4 | Bits per frame, 0 means 16 |
| win_lo | input | 4 | First voting slot of each bit |
| win_hi | input | 4 | Last voting slot of each bit |
| filt_en | input | 1 | Enables the 3-sample majority filter |
| clr_flags | input | 1 | Clears rdy, ovf and smp_err |
| hold_q | output | 16 | Last completed frame |
| rdy | output | 1 | Frame held (valid) |
| ovf | output | 1 | Frame completed while rdy was set |
| smp_err | output | 1 | Window vote was not unanimous |
| line_lvl | output | 1 | Conditioned line level |

## Verification
The assertions assume three things about the inputs:
- rate_inc, bit_count and the window bounds do not change while a frame is in progress.
- win_lo is not above win_hi.
- clr_flags is a short pulse.

The stimulus keeps within these limits. It changes the configuration only while the line has been idle for several bit periods, and it always programs ordered windows.

Disturbances on the line are placed at the middle of a chosen high bit. Their width is either a single clock or several slots. This places each disturbance well inside the voting window whatever the few-cycle delay of the synchroniser and filter.

// File: rtl/rxw_pkg.sv
package rxw_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } rx_state_e;

  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/rxw_cond.sv
module rxw_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic filt_en,
  input  logic line_in,
  output logic line_q,
  output logic fall
);
  import rxw_pkg::*;

  logic [SYNC_STAGES-1:0] sync_q;
  logic s_top, h0, h1, prev_q;

  assign s_top = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      h0     <= 1'b1;
      h1     <= 1'b1;
      line_q <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_in};
      h0     <= s_top;
      h1     <= h0;
      line_q <= filt_en ? vote3(s_top, h0, h1) : s_top;
      prev_q <= line_q;
    end
  end

  assign fall = prev_q & ~line_q;

  // R10: three equal history samples pass straight through the filter
  p_filter_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_en && s_top == h0 && h0 == h1) |=> (line_q == $past(s_top)));

endmodule

// File: rtl/rxw_timer.sv
module rxw_timer #(
  parameter int RATE_W    = 16,
  parameter int SLOT_BITS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 run,
  input  logic [RATE_W-1:0]    rate_inc,
  output logic [SLOT_BITS-1:0] slot,
  output logic                 smp,
  output logic                 bit_end
);
  logic [RATE_W-1:0] len_raw, slot_len, phase;
  logic last_ph;

  assign len_raw  = rate_inc >> SLOT_BITS;
  assign slot_len = (len_raw == '0) ? RATE_W'(1) : len_raw;
  assign last_ph  = (phase >= slot_len - RATE_W'(1));
  assign smp      = run && (phase == '0);
  assign bit_end  = run && last_ph && (slot == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
      slot  <= '0;
    end else if (start) begin
      phase <= '0;
      slot  <= '0;
    end else if (run) begin
      if (last_ph) begin
        phase <= '0;
        slot  <= slot + 1'b1;
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end

  // R1: with a steady rate the phase never passes the slot length
  p_phase_in_slot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !start && $past(run)) |-> (phase < slot_len));

endmodule

// File: rtl/rxw_vote.sv
module rxw_vote #(
  parameter int SLOT_BITS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 smp,
  input  logic                 bit_end,
  input  logic                 lvl,
  input  logic [SLOT_BITS-1:0] slot,
  input  logic [SLOT_BITS-1:0] win_lo,
  input  logic [SLOT_BITS-1:0] win_hi,
  output logic                 bit_val,
  output logic                 bit_err
);
  localparam int C_W = SLOT_BITS + 1;

  logic [C_W-1:0] hi_c, lo_c, hi_n, lo_n, wlen;
  logic in_win;

  assign in_win  = smp && (slot >= win_lo) && (slot <= win_hi);
  assign wlen    = C_W'(win_hi) - C_W'(win_lo) + C_W'(1);
  assign hi_n    = hi_c + C_W'(in_win & lvl);
  assign lo_n    = lo_c + C_W'(in_win & ~lvl);
  assign bit_val = (hi_n == wlen);
  assign bit_err = !((hi_n == wlen) || (lo_n == wlen));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_c <= '0;
      lo_c <= '0;
    end else if (start || bit_end) begin
      hi_c <= '0;
      lo_c <= '0;
    end else begin
      hi_c <= hi_n;
      lo_c <= lo_n;
    end
  end

  // R3: no more samples than slots are ever counted within one bit
  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((C_W+1)'(hi_c) + (C_W+1)'(lo_c)) <= (C_W+1)'(2**SLOT_BITS));

endmodule

// File: rtl/slot_vote_rx.sv
module slot_vote_rx #(
  parameter int HOLD_W      = 16,
  parameter int RATE_W      = 16,
  parameter int SLOT_BITS   = 4,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(HOLD_W)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_en,
  input  logic                 rx_line,
  input  logic [RATE_W-1:0]    rate_inc,
  input  logic [CNT_W-1:0]     bit_count,
  input  logic [SLOT_BITS-1:0] win_lo,
  input  logic [SLOT_BITS-1:0] win_hi,
  input  logic                 filt_en,
  input  logic                 clr_flags,
  output logic [HOLD_W-1:0]    hold_q,
  output logic                 rdy,
  output logic                 ovf,
  output logic                 smp_err,
  output logic                 line_lvl
);
  import rxw_pkg::*;

  rx_state_e st;
  logic line_f, fall, act, start, smp, bit_end, bit_val, bit_err, done;
  logic [SLOT_BITS-1:0] slot;
  logic [HOLD_W-1:0]    shreg;
  logic [CNT_W-1:0]     bit_idx, last_idx;

  rxw_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
    .clk(clk), .rst_n(rst_n), .filt_en(filt_en), .line_in(rx_line),
    .line_q(line_f), .fall(fall)
  );

  rxw_timer #(.RATE_W(RATE_W), .SLOT_BITS(SLOT_BITS)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .run(act), .rate_inc(rate_inc),
    .slot(slot), .smp(smp), .bit_end(bit_end)
  );

  rxw_vote #(.SLOT_BITS(SLOT_BITS)) u_vote (
    .clk(clk), .rst_n(rst_n), .start(start), .smp(smp), .bit_end(bit_end),
    .lvl(line_f), .slot(slot), .win_lo(win_lo), .win_hi(win_hi),
    .bit_val(bit_val), .bit_err(bit_err)
  );

  assign act      = (st == ST_RUN) && rx_en;
  assign start    = (st == ST_IDLE) && rx_en && fall;
  assign last_idx = bit_count - CNT_W'(1);
  assign done     = bit_end && (bit_idx == last_idx);
  assign line_lvl = line_f;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;
    end else begin
      case (st)
        ST_IDLE: if (start) st <= ST_RUN;
        ST_RUN:  if (!rx_en || done) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      bit_idx <= '0;
    end else if (start) begin
      shreg   <= '0;
      bit_idx <= '0;
    end else if (bit_end) begin
      shreg   <= {bit_val, shreg[HOLD_W-1:1]};
      bit_idx <= bit_idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      rdy     <= 1'b0;
      ovf     <= 1'b0;
      smp_err <= 1'b0;
    end else begin
      if (done) hold_q <= {bit_val, shreg[HOLD_W-1:1]};
      rdy     <= done | (rdy & ~clr_flags);
      ovf     <= (done & rdy) | (ovf & ~clr_flags);
      smp_err <= (bit_end & bit_err) | (smp_err & ~clr_flags);
    end
  end

  // R7: overflow can only be present together with ready
  p_ovf_with_rdy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> rdy);

  // R8: a clear with no competing event empties all flags
  p_clear_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_flags && !bit_end) |=> (!rdy && !ovf && !smp_err));

  // R5: hold register only moves at frame completion
  p_hold_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(hold_q));

  // R6: ready rises only after a completed frame
  p_rdy_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy) |-> $past(done));

  // R11: disabling forces the receiver idle
  p_off_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (st == ST_IDLE));

endmodule

// File: tb/sim_slot_vote_rx.sv
`timescale 1ns/1ps
module sim_slot_vote_rx;
  logic clk = 1'b0, rst_n = 1'b0, rx_en = 1'b0, rx_line = 1'b1;
  logic filt_en = 1'b0, clr_flags = 1'b0;
  logic [15:0] rate_inc = 16'd128;
  logic [3:0]  bit_count = 4'd11, win_lo = 4'd5, win_hi = 4'd10;
  wire  [15:0] hold_q;
  wire         rdy, ovf, smp_err, line_lvl;

  int tests = 0, fails = 0;
  bit cmp_on = 1'b0, finished = 1'b0;

  always #10 clk = ~clk;

  slot_vote_rx u0 (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_line(rx_line),
    .rate_inc(rate_inc), .bit_count(bit_count), .win_lo(win_lo),
    .win_hi(win_hi), .filt_en(filt_en), .clr_flags(clr_flags),
    .hold_q(hold_q), .rdy(rdy), .ovf(ovf), .smp_err(smp_err),
    .line_lvl(line_lvl)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: pipelines as values, frame timing from a clock count
  logic m_s1, m_s2, m_h0, m_h1, m_lf, m_pf, m_run, m_rdy, m_ovf, m_err;
  logic [15:0] m_sh, m_hold;
  int m_t, m_hi, m_lo, m_bi, ln, nb, w, sl;
  logic nlf, done, berr, bval;

  always @(posedge clk) begin
    if (!rst_n) begin
      {m_s1, m_s2, m_h0, m_h1, m_lf, m_pf} = 6'b111111;
      m_run = 0; m_rdy = 0; m_ovf = 0; m_err = 0;
      m_sh = 0; m_hold = 0; m_t = 0; m_hi = 0; m_lo = 0; m_bi = 0;
    end else begin
      ln = rate_inc / 16; if (ln == 0) ln = 1;
      nb = (bit_count == 0) ? 16 : bit_count;
      done = 0; berr = 0;
      if (m_run && rx_en) begin
        sl = m_t / ln;
        if (m_t % ln == 0 && sl >= win_lo && sl <= win_hi) begin
          if (m_lf) m_hi++; else m_lo++;
        end
        if (m_t == 16 * ln - 1) begin
          w = win_hi - win_lo + 1;
          bval = (m_hi == w);
          berr = !(m_hi == w || m_lo == w);
          m_sh = {bval, m_sh[15:1]};
          m_hi = 0; m_lo = 0; m_t = 0;
          if (m_bi == nb - 1) begin done = 1; m_run = 0; end
          m_bi++;
        end else m_t++;
      end else if (m_run) begin
        m_run = 0;
      end else if (rx_en && m_pf && !m_lf) begin
        m_run = 1; m_t = 0; m_hi = 0; m_lo = 0; m_sh = 0; m_bi = 0;
      end
      m_ovf = (done && m_rdy) || (m_ovf && !clr_flags);
      m_rdy = done || (m_rdy && !clr_flags);
      m_err = berr || (m_err && !clr_flags);
      if (done) m_hold = m_sh;
      nlf = filt_en ? ((m_s2 & m_h0) | (m_s2 & m_h1) | (m_h0 & m_h1)) : m_s2;
      m_pf = m_lf; m_lf = nlf;
      m_h1 = m_h0; m_h0 = m_s2; m_s2 = m_s1; m_s1 = rx_line;
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      chk("R5 model hold", hold_q, m_hold);
      chk("R6 model rdy", {15'd0, rdy}, {15'd0, m_rdy});
      chk("R7 model ovf", {15'd0, ovf}, {15'd0, m_ovf});
      chk("R3 model smp_err", {15'd0, smp_err}, {15'd0, m_err});
      chk("R9 model line_lvl", {15'd0, line_lvl}, {15'd0, m_lf});
    end
  end

  task automatic send(input logic [15:0] v, input int n, input int ln_c,
                      input int gb, input int gl);
    for (int b = 0; b < n; b++) begin
      for (int c = 0; c < 16 * ln_c; c++) begin
        logic lv;
        lv = v[b];
        if (b == gb && c >= 8 * ln_c - gl / 2 && c < 8 * ln_c - gl / 2 + gl) lv = ~lv;
        @(negedge clk); rx_line = lv;
      end
    end
    @(negedge clk); rx_line = 1'b1;
    repeat (48 * ln_c) @(negedge clk);
  endtask

  task automatic clear();
    @(negedge clk); clr_flags = 1'b1;
    @(negedge clk); clr_flags = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog R4: run did not end, actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1; cmp_on = 1'b1;
    @(negedge clk);
    chk("R12 reset hold", hold_q, 16'h0000);
    chk("R12 reset rdy", {15'd0, rdy}, 16'd0);
    chk("R12 reset line_lvl", {15'd0, line_lvl}, 16'd1);
    rx_en = 1'b1;
    repeat (2000) @(negedge clk);
    chk("R2 idle line starts nothing", {15'd0, rdy}, 16'd0);

    send(16'h04B4, 11, 8, -1, 0);
    chk("R5 R2 first frame hold", hold_q, 16'h9680);
    chk("R6 ready set", {15'd0, rdy}, 16'd1);
    chk("R3 clean frame no error", {15'd0, smp_err}, 16'd0);
    chk("R7 no overflow yet", {15'd0, ovf}, 16'd0);

    send(16'h0586, 11, 8, -1, 0);
    chk("R7 overflow set", {15'd0, ovf}, 16'd1);
    chk("R7 hold replaced", hold_q, 16'hB0C0);
    clear();
    chk("R8 flags cleared", {13'd0, rdy, ovf, smp_err}, 16'd0);

    rate_inc = 16'd256;
    send(16'h04B4, 11, 16, -1, 0);
    chk("R1 slower rate frame", hold_q, 16'h9680);
    clear();
    rate_inc = 16'd128;

    bit_count = 4'd6;
    send(16'h002A, 6, 8, -1, 0);
    chk("R4 six-bit frame", hold_q, 16'hA800);
    chk("R4 six-bit ready", {15'd0, rdy}, 16'd1);
    clear();
    bit_count = 4'd0;
    send(16'hB4A6, 16, 8, -1, 0);
    chk("R4 zero means sixteen", hold_q, 16'hB4A6);
    clear();
    bit_count = 4'd11;

    send(16'h04B4, 11, 8, 2, 24);
    chk("R3 split vote error", {15'd0, smp_err}, 16'd1);
    chk("R3 split vote bit is 0", hold_q, 16'h9600);
    clear();

    rate_inc = 16'd16; win_lo = 4'd4; win_hi = 4'd11; filt_en = 1'b1;
    send(16'h04B4, 11, 1, 2, 1);
    chk("R10 filtered glitch no error", {15'd0, smp_err}, 16'd0);
    chk("R10 filtered glitch hold", hold_q, 16'h9680);
    clear();
    filt_en = 1'b0;
    send(16'h04B4, 11, 1, 2, 1);
    chk("R3 unfiltered glitch error", {15'd0, smp_err}, 16'd1);
    chk("R3 unfiltered glitch hold", hold_q, 16'h9600);
    clear();
    rate_inc = 16'd128; win_lo = 4'd5; win_hi = 4'd10;

    send(16'h0586, 11, 8, -1, 0);
    rx_en = 1'b0;
    send(16'h04B4, 11, 8, -1, 0);
    chk("R11 disabled hold kept", hold_q, 16'hB0C0);
    chk("R11 disabled rdy kept", {15'd0, rdy}, 16'd1);
    chk("R11 disabled ovf kept", {15'd0, ovf}, 16'd0);

    @(negedge clk); rx_line = 1'b0;
    repeat (4) @(negedge clk);
    chk("R9 line low seen", {15'd0, line_lvl}, 16'd0);
    rx_line = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 line high seen", {15'd0, line_lvl}, 16'd1);
    filt_en = 1'b1;
    repeat (4) @(negedge clk);
    rx_line = 1'b0;
    @(negedge clk); rx_line = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk("R10 pulse suppressed", {15'd0, line_lvl}, 16'd1);
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule